// File: doc/BRIEF.md
# Parallel EEPROM Bus Controller

This block sits between a synchronous host and an asynchronous byte-wide EEPROM. It runs one byte read or one byte write at a time. Three active-low strobes drive the memory: chip select, write strobe and output strobe. The host holds a request (address, write data, direction flag) until the controller returns a one-cycle acknowledge. For a read, the returned byte comes with that acknowledge.

Every analog timing minimum is a nanosecond parameter. The controller turns each one into whole clock cycles, rounding up, using the clock period parameter. It covers read access from address and chip select, read access from the output strobe, and the write strobe width. It also covers address hold and data setup around that strobe, and the multi-millisecond self-timed write recovery. After reset, a counter keeps reads back for a short settling time. It refuses writes for a longer inhibit time. A request that arrives while the memory is not yet usable simply waits.

The memory side uses separate drive, enable and sample buses for data. A pad ring or a bench model joins them into one bidirectional bus.

Top module: `eebus_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, ee_ce_n, ee_we_n and ee_oe_n are 1, ee_dq_oe is 0 and req_ack is 0.
- R2: A read (req_write=0) pulls ee_ce_n and ee_oe_n low with ee_we_n high. It keeps ee_dq_oe at 0. It returns on req_rdata the byte the memory presents at ee_addr when req_ack is 1.
- R3: Before a read byte is sampled, ee_ce_n has been low for at least ceil(T_ACC_NS/CLK_NS) cycles and ee_oe_n for at least ceil(T_OE_NS/CLK_NS) cycles.
- R4: A write (req_write=1) pulls ee_ce_n and ee_we_n low with ee_oe_n high. It drives req_wdata on ee_dq_out with ee_dq_oe=1, and that byte is stored at req_addr.
- R5: Each write strobe low pulse lasts exactly ceil(T_WP_NS/CLK_NS) cycles. Parameters giving a pulse under 20 ns, or shorter than the address hold or data setup time, are rejected at elaboration.
- R6: When ee_we_n rises, ee_ce_n is still low, ee_dq_oe is still 1, and ee_addr and ee_dq_out have not changed since the strobe fell.
- R7: After ee_we_n rises, ee_ce_n does not fall again for at least ceil(T_WC_NS/CLK_NS) cycles.
- R8: A read does not start before ceil(T_PUR_NS/CLK_NS) cycles after reset. ee_we_n does not fall before ceil(T_INIT_NS/CLK_NS) cycles after reset. Such requests stay pending and are served afterwards.
- R9: Every request is answered by req_ack high for exactly one cycle once the access is complete. The host holds req_valid and its fields until then.
- R10: ee_dq_oe is 0 in the cycle before ee_oe_n falls and in every cycle ee_oe_n is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rst_n | input | 1 | Asynchronous active-low reset; also marks power-up |
| req_valid | input | 1 | Request pending, held until req_ack |
| req_write | input | 1 | 1 = byte write, 0 = byte read |
| req_addr | input | AW | Byte address |
| req_wdata | input | DW | Byte to write |
| req_ack | output | 1 | One-cycle completion pulse |
| req_rdata | output | DW | Read result, valid with req_ack |
| ee_addr | output | AW | Address to memory |
| ee_dq_out | output | DW | Data driven to memory |
| ee_dq_oe | output | 1 | Enable for ee_dq_out drivers |
| ee_dq_in | input | DW | Data sampled from memory |
| ee_ce_n | output | 1 | Chip select, active low |
| ee_we_n | output | 1 | Write strobe, active low |
| ee_oe_n | output | 1 | Output strobe, active low |

## Verification
The main read/write path gets several kinds of input. A read issued straight out of reset separates the read settling window from the write inhibit window. A write issued inside the inhibit window shows that it is held rather than dropped. A read issued right behind a write exposes any early start during the self-timed recovery. Bytes 00, FF, A5 and 5A at scattered addresses then show that every data bit and address bit travels in both directions and lands at the correct location.

// File: rtl/eebus_pkg.sv
package eebus_pkg;

   // Convert a nanosecond minimum into whole clock cycles, rounding up.
   function automatic int ns_to_cyc(input int ns, input int clk_ns);
      return (ns + clk_ns - 1) / clk_ns;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_R_ADDR = 3'd1,
      ST_R_STRB = 3'd2,
      ST_W_ADDR = 3'd3,
      ST_W_STRB = 3'd4,
      ST_W_HOLD = 3'd5
   } eebus_state_t;

endpackage

// File: rtl/eebus_powerup.sv
module eebus_powerup #(
   parameter int C_RD = 1,
   parameter int C_WR = 1
) (
   input  logic clk,
   input  logic rst_n,
   output logic rd_ok,
   output logic wr_ok
);
   localparam int C_MAX = eebus_pkg::imax(C_RD, C_WR);
   localparam int PW    = $clog2(C_MAX + 2);

   generate
      if (C_MAX == 0) begin : g_no_wait
         assign rd_ok = 1'b1;
         assign wr_ok = 1'b1;
      end else begin : g_wait
         logic [PW-1:0] pu_cnt;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               pu_cnt <= '0;
            end else if (pu_cnt != PW'(C_MAX)) begin
               pu_cnt <= pu_cnt + 1'b1;
            end
         end

         assign rd_ok = (pu_cnt >= PW'(C_RD));
         assign wr_ok = (pu_cnt >= PW'(C_WR));

         // R8
         wr_ok_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $past(wr_ok) |-> wr_ok);
      end
   endgenerate

endmodule

// File: rtl/eebus_busy_timer.sv
module eebus_busy_timer #(
   parameter int C_WC = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic busy
);
   localparam int TW = $clog2(C_WC + 2);

   logic [TW-1:0] rem;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem <= '0;
      end else if (start) begin
         rem <= TW'(C_WC);
      end else if (rem != '0) begin
         rem <= rem - 1'b1;
      end
   end

   assign busy = (rem != '0);

   // R7
   busy_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> busy);

endmodule

// File: rtl/eebus_seq.sv
module eebus_seq #(
   parameter int AW     = 16,
   parameter int DW     = 8,
   parameter int C_RSTB = 1,
   parameter int C_WP   = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   input  logic          rd_ok,
   input  logic          wr_ok,
   input  logic          busy,
   output logic          req_ack,
   output logic [DW-1:0] req_rdata,
   output logic          wr_done,
   output logic [AW-1:0] ee_addr,
   output logic [DW-1:0] ee_dq_out,
   output logic          ee_dq_oe,
   input  logic [DW-1:0] ee_dq_in,
   output logic          ee_ce_n,
   output logic          ee_we_n,
   output logic          ee_oe_n
);
   import eebus_pkg::*;

   localparam int SEQ_MAX = imax(C_RSTB, C_WP);
   localparam int CW      = $clog2(SEQ_MAX + 1);
   localparam int WCW     = $clog2(C_WP + 2) + 1;

   eebus_state_t  state;
   logic [CW-1:0] cnt;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] wdata_q;
   logic [DW-1:0] rdata_q;
   logic          ack_q;

   logic start_rd, start_wr;
   assign start_rd = req_valid && !req_write && rd_ok && !busy && !ack_q;
   assign start_wr = req_valid &&  req_write && wr_ok && !busy && !ack_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
         ack_q   <= 1'b0;
      end else begin
         ack_q <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start_wr) begin
                  state   <= ST_W_ADDR;
                  addr_q  <= req_addr;
                  wdata_q <= req_wdata;
               end else if (start_rd) begin
                  state  <= ST_R_ADDR;
                  addr_q <= req_addr;
               end
            end
            ST_R_ADDR: begin
               state <= ST_R_STRB;
               cnt   <= CW'(C_RSTB - 1);
            end
            ST_R_STRB: begin
               if (cnt == '0) begin
                  rdata_q <= ee_dq_in;
                  ack_q   <= 1'b1;
                  state   <= ST_IDLE;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_W_ADDR: begin
               state <= ST_W_STRB;
               cnt   <= CW'(C_WP - 1);
            end
            ST_W_STRB: begin
               if (cnt == '0) begin
                  state <= ST_W_HOLD;
               end else begin
                  cnt <= cnt - 1'b1;
               end
            end
            ST_W_HOLD: begin
               ack_q <= 1'b1;
               state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign wr_done   = (state == ST_W_HOLD);
   assign req_ack   = ack_q;
   assign req_rdata = rdata_q;
   assign ee_addr   = addr_q;
   assign ee_dq_out = wdata_q;

   always_comb begin
      ee_ce_n  = 1'b1;
      ee_we_n  = 1'b1;
      ee_oe_n  = 1'b1;
      ee_dq_oe = 1'b0;
      unique case (state)
         ST_R_ADDR: ee_ce_n = 1'b0;
         ST_R_STRB: begin
            ee_ce_n = 1'b0;
            ee_oe_n = 1'b0;
         end
         ST_W_ADDR, ST_W_HOLD: begin
            ee_ce_n  = 1'b0;
            ee_dq_oe = 1'b1;
         end
         ST_W_STRB: begin
            ee_ce_n  = 1'b0;
            ee_we_n  = 1'b0;
            ee_dq_oe = 1'b1;
         end
         default: ;
      endcase
   end

   // Length of the current write-strobe low run, for the checks below.
   logic [WCW-1:0] we_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         we_run <= '0;
      end else if (!ee_we_n) begin
         if (we_run != '1) we_run <= we_run + 1'b1;
      end else begin
         we_run <= '0;
      end
   end

   // R5
   we_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ee_we_n) |-> (we_run == WCW'(C_WP)));

   // R6
   we_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ee_we_n) |-> (!ee_ce_n && ee_dq_oe && $stable(ee_addr) && $stable(ee_dq_out)));

   // R9
   ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_ack |=> !req_ack);

   // R10
   no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ee_oe_n) |-> (!ee_dq_oe && $past(!ee_dq_oe)));

   // R4
   we_needs_oe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ee_we_n) |-> (ee_oe_n && $past(!ee_ce_n)));

endmodule

// File: rtl/eebus_ctrl.sv
module eebus_ctrl #(
   parameter int AW        = 16,
   parameter int DW        = 8,
   parameter int CLK_NS    = 10,
   parameter int T_ACC_NS  = 150,
   parameter int T_OE_NS   = 70,
   parameter int T_WP_NS   = 100,
   parameter int T_AH_NS   = 50,
   parameter int T_DS_NS   = 50,
   parameter int T_WC_NS   = 5_000_000,
   parameter int T_INIT_NS = 10_000_000,
   parameter int T_PUR_NS  = 100_000
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_wdata,
   output logic          req_ack,
   output logic [DW-1:0] req_rdata,
   output logic [AW-1:0] ee_addr,
   output logic [DW-1:0] ee_dq_out,
   output logic          ee_dq_oe,
   input  logic [DW-1:0] ee_dq_in,
   output logic          ee_ce_n,
   output logic          ee_we_n,
   output logic          ee_oe_n
);
   import eebus_pkg::*;

   localparam int C_ACC  = ns_to_cyc(T_ACC_NS, CLK_NS);
   localparam int C_OE   = ns_to_cyc(T_OE_NS, CLK_NS);
   localparam int C_RSTB = imax(imax(C_ACC - 1, C_OE), 1);
   localparam int C_WP   = imax(ns_to_cyc(T_WP_NS, CLK_NS), 1);
   localparam int C_WC   = imax(ns_to_cyc(T_WC_NS, CLK_NS), 1);
   localparam int C_INIT = ns_to_cyc(T_INIT_NS, CLK_NS);
   localparam int C_PUR  = ns_to_cyc(T_PUR_NS, CLK_NS);

   // Elaboration-time parameter checks.
   if (CLK_NS < 1) begin : g_bad_clk
      $error("eebus_ctrl: CLK_NS must be positive");
   end
   if (AW < 1 || DW < 1) begin : g_bad_width
      $error("eebus_ctrl: AW and DW must be positive");
   end
   // R5: strobe long enough to start a write and to cover hold and setup.
   if (C_WP * CLK_NS < 20 || C_WP * CLK_NS < T_AH_NS || C_WP * CLK_NS < T_DS_NS) begin : g_bad_wp
      $error("eebus_ctrl: write strobe too short for the timing parameters");
   end

   logic rd_ok, wr_ok, busy, wr_done;

   eebus_powerup #(
      .C_RD (C_PUR),
      .C_WR (C_INIT)
   ) u_powerup (
      .clk   (clk),
      .rst_n (rst_n),
      .rd_ok (rd_ok),
      .wr_ok (wr_ok)
   );

   eebus_busy_timer #(
      .C_WC (C_WC)
   ) u_busy (
      .clk   (clk),
      .rst_n (rst_n),
      .start (wr_done),
      .busy  (busy)
   );

   eebus_seq #(
      .AW     (AW),
      .DW     (DW),
      .C_RSTB (C_RSTB),
      .C_WP   (C_WP)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .rd_ok     (rd_ok),
      .wr_ok     (wr_ok),
      .busy      (busy),
      .req_ack   (req_ack),
      .req_rdata (req_rdata),
      .wr_done   (wr_done),
      .ee_addr   (ee_addr),
      .ee_dq_out (ee_dq_out),
      .ee_dq_oe  (ee_dq_oe),
      .ee_dq_in  (ee_dq_in),
      .ee_ce_n   (ee_ce_n),
      .ee_we_n   (ee_we_n),
      .ee_oe_n   (ee_oe_n)
   );

   // R7
   recovery_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ee_ce_n) |-> !busy);

   // R8
   write_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ee_we_n) |-> wr_ok);

   // R8
   read_settle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ee_oe_n) |-> rd_ok);

endmodule

// File: tb/eebus_ctrl_tb_top.sv
module eebus_ctrl_tb_top;
   localparam int AW     = 8;
   localparam int DW     = 8;
   localparam int CLK_NS = 4;
   localparam int WC_NS  = 400;
   localparam int INI_NS = 2000;
   localparam int PUR_NS = 400;

   // Expected cycle counts, from the requirements.
   localparam int E_ACC  = (150 + CLK_NS - 1) / CLK_NS;
   localparam int E_OE   = (70 + CLK_NS - 1) / CLK_NS;
   localparam int E_WP   = (100 + CLK_NS - 1) / CLK_NS;
   localparam int E_WC   = (WC_NS + CLK_NS - 1) / CLK_NS;
   localparam int E_INIT = (INI_NS + CLK_NS - 1) / CLK_NS;
   localparam int E_PUR  = (PUR_NS + CLK_NS - 1) / CLK_NS;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [DW-1:0] req_wdata = '0;
   logic          req_ack;
   logic [DW-1:0] req_rdata;
   logic [AW-1:0] ee_addr;
   logic [DW-1:0] ee_dq_out;
   logic          ee_dq_oe;
   logic [DW-1:0] ee_dq_in;
   logic          ee_ce_n, ee_we_n, ee_oe_n;

   always #(CLK_NS / 2) clk = ~clk;

   eebus_ctrl #(
      .AW(AW), .DW(DW), .CLK_NS(CLK_NS),
      .T_WC_NS(WC_NS), .T_INIT_NS(INI_NS), .T_PUR_NS(PUR_NS)
   ) dut_i (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .req_ack(req_ack), .req_rdata(req_rdata),
      .ee_addr(ee_addr), .ee_dq_out(ee_dq_out), .ee_dq_oe(ee_dq_oe),
      .ee_dq_in(ee_dq_in),
      .ee_ce_n(ee_ce_n), .ee_we_n(ee_we_n), .ee_oe_n(ee_oe_n)
   );

   // Memory model: stores on the write strobe's rising edge.
   logic [DW-1:0] mem [0:(1<<AW)-1];
   initial begin
      for (int i = 0; i < (1 << AW); i++) mem[i] = DW'(i) ^ 8'h3C;
   end
   always @(posedge ee_we_n) if (!ee_ce_n) mem[ee_addr] <= ee_dq_out;
   assign ee_dq_in = (!ee_ce_n && !ee_oe_n) ? mem[ee_addr] : '0;

   // Monitor, sampled on falling edges.
   int cyc = 0;
   int ce_run = 0, oe_run = 0, we_run = 0;
   int last_ce_run = 0, last_oe_run = 0, last_we_run = 0;
   int first_ce_low = -1, first_we_low = -1;
   int last_we_rise = -1, last_gap = -1;
   int viol_r4 = 0, viol_r6 = 0, viol_r10 = 0;
   logic p_ce = 1'b1, p_we = 1'b1, p_oe = 1'b1, p_dqoe = 1'b0;
   logic [AW-1:0] we_addr;
   logic [DW-1:0] we_data;

   always @(negedge clk) begin
      if (!rst_n) begin
         cyc <= 0;
      end else begin
         cyc <= cyc + 1;
         if (!ee_ce_n) ce_run <= ce_run + 1;
         if (!ee_oe_n) oe_run <= oe_run + 1;
         if (!ee_we_n) we_run <= we_run + 1;
         if (p_ce && !ee_ce_n) begin
            if (first_ce_low < 0) first_ce_low <= cyc;
            if (last_we_rise >= 0) last_gap <= cyc - last_we_rise;
         end
         if (!p_ce && ee_ce_n) begin last_ce_run <= ce_run; ce_run <= 0; end
         if (!p_oe && ee_oe_n) begin last_oe_run <= oe_run; oe_run <= 0; end
         if (p_we && !ee_we_n) begin
            if (first_we_low < 0) first_we_low <= cyc;
            we_addr <= ee_addr;
            we_data <= ee_dq_out;
         end
         if (!ee_we_n && (!ee_oe_n || ee_ce_n || !ee_dq_oe)) viol_r4 <= viol_r4 + 1;
         if (!p_we && !ee_we_n && (ee_addr != we_addr || ee_dq_out != we_data)) viol_r6 <= viol_r6 + 1;
         if (!p_we && ee_we_n) begin
            last_we_run <= we_run; we_run <= 0; last_we_rise <= cyc;
            if (ee_ce_n || !ee_dq_oe || ee_addr != we_addr || ee_dq_out != we_data) viol_r6 <= viol_r6 + 1;
         end
         if ((!ee_oe_n && ee_dq_oe) || (p_oe && !ee_oe_n && p_dqoe)) viol_r10 <= viol_r10 + 1;
         p_ce <= ee_ce_n; p_we <= ee_we_n; p_oe <= ee_oe_n; p_dqoe <= ee_dq_oe;
      end
   end

   int n_chk = 0, n_fail = 0;

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // One request; returns the read byte. Checks the one-cycle acknowledge (R9).
   task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                         output logic [DW-1:0] rd);
      int waited = 0;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      do begin
         @(negedge clk);
         waited++;
      end while (!req_ack && waited < 20000);
      rd = req_rdata;
      req_valid = 1'b0;
      @(negedge clk);
      chk(!req_ack, "R9", "ack longer than one cycle", int'(req_ack), 0);
   endtask

   task automatic t_reset();
      repeat (3) @(negedge clk);
      chk(ee_ce_n == 1'b1, "R1", "ce_n in reset", int'(ee_ce_n), 1);
      chk(ee_we_n == 1'b1, "R1", "we_n in reset", int'(ee_we_n), 1);
      chk(ee_oe_n == 1'b1, "R1", "oe_n in reset", int'(ee_oe_n), 1);
      chk(ee_dq_oe == 1'b0 && req_ack == 1'b0, "R1", "dq_oe/ack in reset", int'(ee_dq_oe), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(ee_ce_n && ee_we_n && ee_oe_n && !ee_dq_oe, "R1", "idle after reset", int'(ee_ce_n), 1);
   endtask

   task automatic t_early_read();
      logic [DW-1:0] rd;
      access(1'b0, 8'h03, '0, rd);
      chk(rd == (8'h03 ^ 8'h3C), "R2", "early read data", int'(rd), int'(8'h03 ^ 8'h3C));
      chk(first_ce_low >= E_PUR, "R8", "read start cycle", first_ce_low, E_PUR);
      chk(last_ce_run >= E_ACC, "R3", "ce low before sample", last_ce_run, E_ACC);
      chk(last_oe_run >= E_OE, "R3", "oe low before sample", last_oe_run, E_OE);
   endtask

   task automatic t_inhibited_write();
      logic [DW-1:0] rd;
      access(1'b1, 8'h40, 8'hC3, rd);
      chk(first_we_low >= E_INIT, "R8", "first write strobe cycle", first_we_low, E_INIT);
      chk(last_we_run == E_WP, "R5", "write strobe width", last_we_run, E_WP);
      chk(mem[8'h40] == 8'hC3, "R4", "byte stored", int'(mem[8'h40]), int'(8'hC3));
   endtask

   task automatic t_read_behind_write();
      logic [DW-1:0] rd;
      access(1'b1, 8'h41, 8'h96, rd);
      access(1'b0, 8'h41, '0, rd);
      chk(last_gap >= E_WC, "R7", "write recovery gap", last_gap, E_WC);
      chk(rd == 8'h96, "R2", "read back after write", int'(rd), int'(8'h96));
   endtask

   task automatic t_patterns();
      logic [DW-1:0] rd;
      logic [DW-1:0] pat [4] = '{8'h00, 8'hFF, 8'hA5, 8'h5A};
      logic [AW-1:0] adr [4] = '{8'h00, 8'hFF, 8'h5A, 8'hA5};
      for (int i = 0; i < 4; i++) access(1'b1, adr[i], pat[i], rd);
      for (int i = 0; i < 4; i++) begin
         access(1'b0, adr[i], '0, rd);
         chk(rd == pat[i], "R4", "pattern read back", int'(rd), int'(pat[i]));
      end
      chk(last_we_run == E_WP, "R5", "strobe width, pattern run", last_we_run, E_WP);
   endtask

   task automatic t_bus_rules();
      chk(viol_r4 == 0, "R4", "strobe combination faults", viol_r4, 0);
      chk(viol_r6 == 0, "R6", "hold faults at strobe rise", viol_r6, 0);
      chk(viol_r10 == 0, "R10", "driver overlap faults", viol_r10, 0);
   endtask

   bit timed_out = 1'b0;

   initial begin
      fork
         begin
            t_reset();
            t_early_read();
            t_inhibited_write();
            t_read_behind_write();
            t_patterns();
            t_bus_rules();
         end
         begin
            repeat (150000) @(posedge clk);
            timed_out = 1'b1;
         end
      join_any
      if (timed_out) chk(1'b0, "R9", "watchdog expired", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule